// File: doc/BRIEF.md
# Vehicle Alarm Sequencer

This block is the central controller of a car anti-theft system. It watches clean, clock-synchronous levels from the ignition switch and from the driver and passenger doors. From them it decides when the car is armed, when an intrusion countdown is running, when the siren sounds and when the owner has disarmed the system.

It does not count time itself. An external countdown timer is loaded through a one-cycle start pulse and a 2-bit interval select that names one of four programmed durations. The timer reports back through an expired flag. A once-per-second enable drives the blink of the dashboard LED. A reprogram pulse, raised whenever a duration is changed, forces the sequencer back to the armed mode.

Top module: `alarm_seq`

## Requirements
- R1: After reset the sequencer is in the armed mode: siren off, start low, LED low until the first one-second enable, interval select 00.
- R2: In armed mode with the ignition off, a driver door opening issues a start pulse with interval 01. A passenger door opening issues a start pulse with interval 10. Both doors opening in the same cycle use 01. The sequencer then enters the triggered mode.
- R3: Ignition on in any mode, without reprogram, moves the sequencer to disarmed in the next cycle. The LED and the siren are then off.
- R4: Timer expiry in the triggered mode turns the siren on.
- R5: The siren stays on while any door is open. When all doors are closed, a start pulse with interval 11 is issued, and expiry of that interval returns to armed. A reopened door suspends that return until the doors close again and a new start pulse is issued.
- R6: Disarmed mode waits for ignition off, then for the driver door to open, then for all doors to be closed. It then issues a start pulse with interval 00 and arms on expiry.
- R7: A door opening during the arming delay holds the sequencer until all doors are closed. A fresh start pulse with interval 00 then restarts the delay from its full length.
- R8: A reprogram pulse puts the sequencer in armed mode in the next cycle, with no start pulse in that cycle. From there it reacts at once to the current inputs.
- R9: The LED toggles on every one-second enable in armed mode. It is steadily on in triggered and siren modes and off in disarmed modes. The siren is on only in the siren mode.
- R10: The start pulse lasts one cycle. The interval select changes only together with a start pulse.
- R11: The expired flag is ignored in the cycle the start pulse is out, and is acted on from the next cycle. A zero-length interval therefore finishes one cycle after its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ign_i | input | 1 | Ignition on level |
| drv_door_i | input | 1 | Driver door open level |
| pas_door_i | input | 1 | Passenger door open level |
| expired_i | input | 1 | Countdown timer at zero |
| tick_1hz_i | input | 1 | One-cycle enable once per second |
| reprog_i | input | 1 | Duration reprogrammed, one-cycle pulse |
| interval_o | output | 2 | Duration select: 00 arming, 01 driver, 10 passenger, 11 siren |
| start_o | output | 1 | One-cycle timer load pulse |
| led_o | output | 1 | Status LED drive |
| siren_o | output | 1 | Siren enable |

## Verification
A timer start and a timer expiry can fall in the same cycle. This happens when the stale expired flag from the previous countdown is still high as a new countdown is launched, or when a duration has been set to zero. The bench lets an earlier countdown run out and then programs a zero driver delay. It requires the triggered mode to survive the start cycle and the siren to come on exactly one cycle later. The bench also drives ignition, doors and reprogram together in random runs and compares every cycle against its own mode model.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  typedef enum logic [3:0] {
    ST_ARMED,
    ST_TRIG,
    ST_ALARM_OPEN,
    ST_ALARM_SHUT,
    ST_DIS_IGN,
    ST_DIS_OPEN,
    ST_DIS_SHUT,
    ST_ARMING,
    ST_ARM_HOLD
  } alarm_state_e;

  localparam int unsigned SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_ARM   = 2'b00;
  localparam logic [SEL_W-1:0] SEL_DRV   = 2'b01;
  localparam logic [SEL_W-1:0] SEL_PAS   = 2'b10;
  localparam logic [SEL_W-1:0] SEL_SIREN = 2'b11;
endpackage

// File: rtl/alarm_fsm.sv
module alarm_fsm
  import alarm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ign_i,
  input  logic             drv_door_i,
  input  logic             pas_door_i,
  input  logic             expired_i,
  input  logic             reprog_i,
  output alarm_state_e     state_o,
  output logic             start_o,
  output logic [SEL_W-1:0] interval_o
);
  alarm_state_e     state_q, state_d;
  logic             start_q, start_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             door_any, exp_ok;

  assign door_any = drv_door_i | pas_door_i;
  // expired is stale while the load pulse is out
  assign exp_ok   = expired_i & ~start_q;

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    sel_d   = sel_q;
    if (reprog_i) begin
      state_d = ST_ARMED;
    end else if (ign_i) begin
      state_d = ST_DIS_IGN;
    end else begin
      case (state_q)
        ST_ARMED: begin
          if (drv_door_i) begin
            state_d = ST_TRIG; start_d = 1'b1; sel_d = SEL_DRV;
          end else if (pas_door_i) begin
            state_d = ST_TRIG; start_d = 1'b1; sel_d = SEL_PAS;
          end
        end
        ST_TRIG:       if (exp_ok) state_d = ST_ALARM_OPEN;
        ST_ALARM_OPEN: if (!door_any) begin
          state_d = ST_ALARM_SHUT; start_d = 1'b1; sel_d = SEL_SIREN;
        end
        ST_ALARM_SHUT: begin
          if (door_any)    state_d = ST_ALARM_OPEN;
          else if (exp_ok) state_d = ST_ARMED;
        end
        ST_DIS_IGN:    state_d = ST_DIS_OPEN;
        ST_DIS_OPEN:   if (drv_door_i) state_d = ST_DIS_SHUT;
        ST_DIS_SHUT, ST_ARM_HOLD: if (!door_any) begin
          state_d = ST_ARMING; start_d = 1'b1; sel_d = SEL_ARM;
        end
        ST_ARMING: begin
          if (door_any)    state_d = ST_ARM_HOLD;
          else if (exp_ok) state_d = ST_ARMED;
        end
        default:       state_d = ST_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ARMED;
      start_q <= 1'b0;
      sel_q   <= SEL_ARM;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      sel_q   <= sel_d;
    end
  end

  assign state_o    = state_q;
  assign start_o    = start_q;
  assign interval_o = sel_q;

  assert_start_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
  assert_sel_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_q |-> $stable(sel_q));
  assert_reprog_armed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reprog_i |=> (state_q == ST_ARMED && !start_q));
  assert_ign_disarm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ign_i && !reprog_i) |=> state_q == ST_DIS_IGN);
  assert_trig_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && !reprog_i && !ign_i && door_any)
    |=> (start_q && state_q == ST_TRIG
         && sel_q == ($past(drv_door_i) ? SEL_DRV : SEL_PAS)));
  assert_stale_expiry_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && state_q == ST_TRIG && !reprog_i && !ign_i) |=> state_q == ST_TRIG);
endmodule

// File: rtl/alarm_blink.sv
module alarm_blink (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_1hz_i,
  output logic blink_o
);
  logic blink_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         blink_q <= 1'b0;
    else if (tick_1hz_i) blink_q <= ~blink_q;
  end

  assign blink_o = blink_q;

  assert_blink_toggle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_1hz_i |=> blink_q != $past(blink_q));
endmodule

// File: rtl/alarm_out.sv
module alarm_out
  import alarm_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  alarm_state_e state_i,
  input  logic         blink_i,
  output logic         led_o,
  output logic         siren_o
);
  always_comb begin
    led_o   = 1'b0;
    siren_o = 1'b0;
    case (state_i)
      ST_ARMED:                     led_o = blink_i;
      ST_TRIG:                      led_o = 1'b1;
      ST_ALARM_OPEN, ST_ALARM_SHUT: begin led_o = 1'b1; siren_o = 1'b1; end
      default: ;
    endcase
  end

  assert_siren_led_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    siren_o |-> led_o);
endmodule

// File: rtl/alarm_seq.sv
module alarm_seq
  import alarm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ign_i,
  input  logic       drv_door_i,
  input  logic       pas_door_i,
  input  logic       expired_i,
  input  logic       tick_1hz_i,
  input  logic       reprog_i,
  output logic [1:0] interval_o,
  output logic       start_o,
  output logic       led_o,
  output logic       siren_o
);
  alarm_state_e state;
  logic         blink;

  alarm_fsm i_fsm (
    .clk_i, .rst_ni, .ign_i, .drv_door_i, .pas_door_i, .expired_i, .reprog_i,
    .state_o(state), .start_o, .interval_o
  );

  alarm_blink i_blink (.clk_i, .rst_ni, .tick_1hz_i, .blink_o(blink));

  alarm_out i_out (.clk_i, .rst_ni, .state_i(state), .blink_i(blink), .led_o, .siren_o);
endmodule

// File: tb/test_alarm_seq.sv
`timescale 1ns/1ps
module test_alarm_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ign = 0, drv = 0, pas = 0, tick = 0, reprog = 0;
  logic expired, start, led, siren;
  logic [1:0] interval;
  logic [3:0] tcnt;
  logic [3:0] val [4];
  int checks = 0, errors = 0, cyc = 0;

  localparam int M_ARMED = 0, M_TRIG = 1, M_AOPEN = 2, M_ASHUT = 3, M_DIGN = 4,
                 M_DOPEN = 5, M_DSHUT = 6, M_ARMING = 7, M_HOLD = 8;
  int m = M_ARMED, nm;
  bit mst = 0, nst, mblink = 0;
  logic [1:0] msel = 2'b00, nsel;

  always #4 clk = ~clk;

  alarm_seq i_alarm_seq (
    .clk_i(clk), .rst_ni(rst_n), .ign_i(ign), .drv_door_i(drv), .pas_door_i(pas),
    .expired_i(expired), .tick_1hz_i(tick), .reprog_i(reprog),
    .interval_o(interval), .start_o(start), .led_o(led), .siren_o(siren));

  // environment: countdown timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tcnt <= '0;
    else if (start)            tcnt <= val[interval];
    else if (tick && tcnt != 0) tcnt <= tcnt - 1'b1;
  end
  assign expired = (tcnt == 0);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_next();
    bit door = drv | pas;
    bit eok = expired & !mst;
    nm = m; nst = 0; nsel = msel;
    if (reprog) nm = M_ARMED;
    else if (ign) nm = M_DIGN;
    else case (m)
      M_ARMED:  if (drv) begin nm = M_TRIG; nst = 1; nsel = 2'b01; end
                else if (pas) begin nm = M_TRIG; nst = 1; nsel = 2'b10; end
      M_TRIG:   if (eok) nm = M_AOPEN;
      M_AOPEN:  if (!door) begin nm = M_ASHUT; nst = 1; nsel = 2'b11; end
      M_ASHUT:  if (door) nm = M_AOPEN; else if (eok) nm = M_ARMED;
      M_DIGN:   nm = M_DOPEN;
      M_DOPEN:  if (drv) nm = M_DSHUT;
      M_DSHUT, M_HOLD: if (!door) begin nm = M_ARMING; nst = 1; nsel = 2'b00; end
      M_ARMING: if (door) nm = M_HOLD; else if (eok) nm = M_ARMED;
      default:  nm = M_ARMED;
    endcase
  endtask

  task automatic step();
    tick = (cyc % 4 == 3);
    cyc++;
    #1;
    model_next();
    @(posedge clk);
    m = nm; mst = nst; msel = nsel;
    if (tick) mblink = !mblink;
    @(negedge clk);
    begin
      bit eled = (m == M_ARMED) ? mblink : (m == M_TRIG || m == M_AOPEN || m == M_ASHUT);
      bit esir = (m == M_AOPEN || m == M_ASHUT);
      chk(led == eled, "R9 led", led, eled);
      chk(siren == esir, "R4 siren", siren, esir);
      chk(start == mst, "R10 start", start, mst);
      chk(interval == msel, "R10 interval", interval, msel);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit seen0, seen1;
    void'($urandom(32'd4242));
    val[0] = 4'd2; val[1] = 4'd2; val[2] = 4'd3; val[3] = 4'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(led == 0 && siren == 0 && start == 0 && interval == 0, "R1 reset", {led, siren, start}, 0);

    drv = 1; step();
    chk(start && interval == 2'b01 && led, "R2 driver", interval, 1);
    for (int i = 0; i < 60 && !siren; i++) step();
    chk(siren == 1, "R4 expiry", siren, 1);
    repeat (12) step();
    chk(siren == 1, "R5 door open", siren, 1);
    drv = 0; step();
    chk(start && interval == 2'b11 && siren, "R5 siren timer", interval, 3);
    for (int i = 0; i < 60 && siren; i++) step();
    chk(siren == 0, "R5 return", siren, 0);

    drv = 1; pas = 1; step();
    chk(start && interval == 2'b01, "R2 both doors", interval, 1);
    ign = 1; step();
    chk(led == 0 && siren == 0, "R3 ignition", led, 0);

    drv = 0; pas = 0; ign = 0; step();
    drv = 1; step();
    drv = 0; step();
    chk(start && interval == 2'b00, "R6 arming start", {start, interval}, 4);
    pas = 1; step();
    pas = 0; step();
    chk(start && interval == 2'b00, "R7 arming restart", {start, interval}, 4);
    repeat (20) step();
    pas = 1; step();
    chk(start && interval == 2'b10, "R6 armed", interval, 2);

    reprog = 1; step();
    chk(start == 0 && siren == 0, "R8 reprog", start, 0);
    reprog = 0; step();
    chk(start && interval == 2'b10, "R8 immediate", interval, 2);

    pas = 0; val[1] = 4'd0; reprog = 1; step();
    reprog = 0; repeat (20) step();
    drv = 1; step();
    chk(start && interval == 2'b01, "R11 start", interval, 1);
    step();
    chk(siren == 0, "R11 stale ignored", siren, 0);
    step();
    chk(siren == 1, "R11 zero delay", siren, 1);
    drv = 0;
    for (int i = 0; i < 60 && siren; i++) step();
    seen0 = 0; seen1 = 0;
    repeat (10) begin step(); if (led) seen1 = 1; else seen0 = 1; end
    chk(seen0 && seen1, "R9 blink", {seen1, seen0}, 3);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 40 == 0) ign = !ign;
      if ($urandom % 6 == 0) drv = !drv;
      if ($urandom % 10 == 0) pas = !pas;
      reprog = ($urandom % 150 == 0);
      if (reprog) val[$urandom % 4] = 4'($urandom % 5);
      step();
    end
    reprog = 0;

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule